// File: doc/BRIEF.md
# Power Management Event Controller

This block is a register-mapped power management unit. It keeps a free-running power management timer, a 16-bit event status register with write-one-to-clear semantics, an event enable register and a control register. A level interrupt to the operating system (`sci`) is raised whenever an enabled event is pending. A separate two-byte port carries an advanced power management command byte and a status byte. Two command values switch the interrupt-routing enable bit in the control register, and every command write can raise a one-cycle SMI request.

Software reaches the registers through a simple bus with single-cycle write strobes and a registered read path. Read data appears one cycle after the read strobe. Writing the control register with its suspend-enable bit set starts a suspend action. Suspend type 0 pulses a power-off request. Suspend type 1 marks resume and power-button status and pulses a reset request. The timer advances on a tick-enable input that runs at the 3.579545 MHz timer rate. A power-button event input is counted only while its enable bit is set.

Top module: `pmu_evt_ctrl`

## Requirements
- R1: After reset every register, the timer, `pm_rdata`, `apm_rdata` and every output are zero.
- R2: The timer is `TMR_W` bits wide (default 24) and advances by one, wrapping, on each cycle with `tick_en` high. A read at offset 0x08 returns it in the low bits of the 32-bit word, with the upper bits zero. Writes to 0x08 are ignored.
- R3: Status bit 0 is set on each cycle in which a tick changes the timer's top bit. Both the rise and the wrap to zero count.
- R4: The status register (offset 0x00) clears each bit written as 1. An event that sets a bit in the same cycle wins over the clear.
- R5: The enable register (offset 0x02) is read/write. `sci` is high exactly when status AND enable is nonzero in bit 10, 8, 5 or 0.
- R6: The control register (offset 0x04) stores all written bits except bit 13, which always reads 0. Bits 12:10 are the suspend type.
- R7: A control write with bit 13 set pulses `shutdown_req` for type 0. For type 1 it sets status bits 15 and 8 and pulses `reset_req`. Other types have no effect. Each pulse lasts one cycle and comes in the cycle after the write.
- R8: A `pwrbtn_evt` sets status bit 8 only while enable bit 8 is 1.
- R9: A write to the command byte (`apm_sel`=0) stores it. Value 0xF1 sets control bit 0 and 0xF0 clears it. This takes priority over a control write in the same cycle.
- R10: `smi_req` pulses for one cycle, the cycle after a command-byte write, exactly when `smi_cfg_en` was 1 during the write.
- R11: The status byte (`apm_sel`=1) is a plain read/write byte.
- R12: Register reads return data in the cycle after the read strobe. The value is the register contents before any same-cycle write. A read of an unmapped offset returns zero. Read data holds between reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pm_wr | input | 1 | Register write strobe |
| pm_rd | input | 1 | Register read strobe |
| pm_addr | input | 6 | Register byte offset |
| pm_wdata | input | 16 | Register write data |
| pm_rdata | output | 32 | Registered read data |
| apm_wr | input | 1 | Command/status port write strobe |
| apm_rd | input | 1 | Command/status port read strobe |
| apm_sel | input | 1 | 0 selects command byte, 1 status byte |
| apm_wdata | input | 8 | Port write data |
| apm_rdata | output | 8 | Registered port read data |
| tick_en | input | 1 | Timer advance enable |
| pwrbtn_evt | input | 1 | Power-button event |
| smi_cfg_en | input | 1 | Allows SMI on command writes |
| sci | output | 1 | Level system control interrupt |
| smi_req | output | 1 | One-cycle SMI request |
| shutdown_req | output | 1 | One-cycle power-off request |
| reset_req | output | 1 | One-cycle reset request |

## Verification
Every register, both read paths and all three request strobes have one register between the stimulus edge and the result. So the results of inputs driven before edge N are sampled at the falling edge that follows edge N. `sci` is derived from the status and enable registers with no further register, so it also changes at edge N. The bench drives its inputs at a falling edge and updates its own model of the next state from the requirements. It then compares all outputs at the next falling edge, so every check falls exactly one edge after its stimulus. Timer overflow is reached in a short run because the bench builds the block with a narrow timer.

// File: rtl/pmu_pkg.sv
package pmu_pkg;
  localparam logic [5:0]  OFS_STS = 6'h00;
  localparam logic [5:0]  OFS_EN  = 6'h02;
  localparam logic [5:0]  OFS_CTL = 6'h04;
  localparam logic [5:0]  OFS_TMR = 6'h08;
  localparam int          SUSP_GO_BIT = 13;
  localparam logic [15:0] SCI_SRC_MASK = 16'h0521;
  localparam logic [7:0]  CMD_SCI_ON  = 8'hF1;
  localparam logic [7:0]  CMD_SCI_OFF = 8'hF0;
  localparam logic [2:0]  SUSP_OFF = 3'd0;
  localparam logic [2:0]  SUSP_RST = 3'd1;

  function automatic logic sci_level(logic [15:0] sts, logic [15:0] en);
    return |(sts & en & SCI_SRC_MASK);
  endfunction

  // top bit flips when all lower bits are ones and the counter advances
  function automatic logic top_flip(logic [31:0] low_ones, logic tick);
    return tick & low_ones[0];
  endfunction
endpackage

// File: rtl/pmu_tmr.sv
module pmu_tmr #(
  parameter int TMR_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  output logic [TMR_W-1:0] cnt,
  output logic             ovf_evt
);
  import pmu_pkg::*;
  localparam int LOW_W = TMR_W - 1;

  logic low_full;
  assign low_full = &cnt[LOW_W-1:0];
  assign ovf_evt  = top_flip({31'd0, low_full}, tick_en);

  always_ff @(posedge clk) begin
    if (!rst_n)       cnt <= '0;
    else if (tick_en) cnt <= cnt + 1'b1;
  end

  // R2
  tmr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_en |=> cnt == TMR_W'($past(cnt) + 1'b1));
  // R2
  tmr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en |=> $stable(cnt));
  // R3
  tmr_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> cnt[TMR_W-1] != $past(cnt[TMR_W-1]));
endmodule

// File: rtl/pmu_apm.sv
module pmu_apm (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr,
  input  logic       rd,
  input  logic       sel,
  input  logic [7:0] wdata,
  input  logic       smi_cfg_en,
  output logic [7:0] rdata,
  output logic       smi_req,
  output logic       sci_on,
  output logic       sci_off
);
  import pmu_pkg::*;
  logic [7:0] cmd_q, stat_q;
  logic       cmd_wr;

  assign cmd_wr  = wr && !sel;
  assign sci_on  = cmd_wr && (wdata == CMD_SCI_ON);
  assign sci_off = cmd_wr && (wdata == CMD_SCI_OFF);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q   <= '0;
      stat_q  <= '0;
      rdata   <= '0;
      smi_req <= 1'b0;
    end else begin
      if (cmd_wr)        cmd_q  <= wdata;
      if (wr && sel)     stat_q <= wdata;
      if (rd)            rdata  <= sel ? stat_q : cmd_q;
      smi_req <= cmd_wr && smi_cfg_en;
    end
  end

  // R10
  smi_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    smi_req |-> $past(wr) && !$past(sel) && $past(smi_cfg_en));
  // R9
  cmd_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_wr |=> $stable(cmd_q));
endmodule

// File: rtl/pmu_evt_ctrl.sv
module pmu_evt_ctrl #(
  parameter int TMR_W = 24
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        pm_wr,
  input  logic        pm_rd,
  input  logic [5:0]  pm_addr,
  input  logic [15:0] pm_wdata,
  output logic [31:0] pm_rdata,
  input  logic        apm_wr,
  input  logic        apm_rd,
  input  logic        apm_sel,
  input  logic [7:0]  apm_wdata,
  output logic [7:0]  apm_rdata,
  input  logic        tick_en,
  input  logic        pwrbtn_evt,
  input  logic        smi_cfg_en,
  output logic        sci,
  output logic        smi_req,
  output logic        shutdown_req,
  output logic        reset_req
);
  import pmu_pkg::*;
  localparam int RD_W = 32;

  logic [TMR_W-1:0] tmr_cnt;
  logic             tmr_ovf;
  logic             sci_on, sci_off;
  logic [15:0]      sts_q, en_q, ctl_q;
  logic [15:0]      sts_set, sts_clr, sts_d, ctl_d;
  logic             wr_sts, wr_en, wr_ctl, susp_go, off_d, rst_d, btn_set;
  logic [2:0]       susp_typ;
  logic [RD_W-1:0]  rd_mux;

  pmu_tmr #(.TMR_W(TMR_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .cnt(tmr_cnt), .ovf_evt(tmr_ovf)
  );

  pmu_apm u_apm (
    .clk(clk), .rst_n(rst_n), .wr(apm_wr), .rd(apm_rd), .sel(apm_sel),
    .wdata(apm_wdata), .smi_cfg_en(smi_cfg_en), .rdata(apm_rdata),
    .smi_req(smi_req), .sci_on(sci_on), .sci_off(sci_off)
  );

  assign wr_sts   = pm_wr && (pm_addr == OFS_STS);
  assign wr_en    = pm_wr && (pm_addr == OFS_EN);
  assign wr_ctl   = pm_wr && (pm_addr == OFS_CTL);
  assign susp_go  = wr_ctl && pm_wdata[SUSP_GO_BIT];
  assign susp_typ = pm_wdata[12:10];
  assign off_d    = susp_go && (susp_typ == SUSP_OFF);
  assign rst_d    = susp_go && (susp_typ == SUSP_RST);
  assign btn_set  = pwrbtn_evt && en_q[8];

  assign sts_set = {rst_d, 6'b0, (rst_d | btn_set), 7'b0, tmr_ovf};
  assign sts_clr = wr_sts ? pm_wdata : 16'h0000;
  assign sts_d   = (sts_q & ~sts_clr) | sts_set;

  always_comb begin
    ctl_d = ctl_q;
    if (wr_ctl) ctl_d = pm_wdata & ~(16'h1 << SUSP_GO_BIT);
    if (sci_on)       ctl_d[0] = 1'b1;
    else if (sci_off) ctl_d[0] = 1'b0;
  end

  always_comb begin
    case (pm_addr)
      OFS_STS: rd_mux = {16'h0, sts_q};
      OFS_EN:  rd_mux = {16'h0, en_q};
      OFS_CTL: rd_mux = {16'h0, ctl_q};
      OFS_TMR: rd_mux = RD_W'(tmr_cnt);
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sts_q        <= '0;
      en_q         <= '0;
      ctl_q        <= '0;
      pm_rdata     <= '0;
      shutdown_req <= 1'b0;
      reset_req    <= 1'b0;
    end else begin
      sts_q        <= sts_d;
      ctl_q        <= ctl_d;
      if (wr_en) en_q <= pm_wdata;
      if (pm_rd) pm_rdata <= rd_mux;
      shutdown_req <= off_d;
      reset_req    <= rst_d;
    end
  end

  assign sci = sci_level(sts_q, en_q);

  // R3
  ovf_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_ovf |=> sts_q[0]);
  // R6
  susp_bit_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_q[SUSP_GO_BIT]);
  // R7
  rst_marks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |-> sts_q[15] && sts_q[8]);
  // R7
  one_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({shutdown_req, reset_req}));
  // R8
  btn_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pwrbtn_evt && en_q[8]) |=> sts_q[8]);
  // R9
  sci_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sci_on |=> ctl_q[0]);
endmodule

// File: tb/pmu_evt_ctrl_test.sv
module pmu_evt_ctrl_test;
  localparam int TW = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic pm_wr = 0, pm_rd = 0, apm_wr = 0, apm_rd = 0, apm_sel = 0;
  logic [5:0] pm_addr = 0;
  logic [15:0] pm_wdata = 0;
  logic [7:0] apm_wdata = 0;
  logic tick_en = 0, pwrbtn_evt = 0, smi_cfg_en = 0;
  logic [31:0] pm_rdata;
  logic [7:0] apm_rdata;
  logic sci, smi_req, shutdown_req, reset_req;

  pmu_evt_ctrl #(.TMR_W(TW)) uut (
    .clk(clk), .rst_n(rst_n), .pm_wr(pm_wr), .pm_rd(pm_rd), .pm_addr(pm_addr),
    .pm_wdata(pm_wdata), .pm_rdata(pm_rdata), .apm_wr(apm_wr), .apm_rd(apm_rd),
    .apm_sel(apm_sel), .apm_wdata(apm_wdata), .apm_rdata(apm_rdata),
    .tick_en(tick_en), .pwrbtn_evt(pwrbtn_evt), .smi_cfg_en(smi_cfg_en),
    .sci(sci), .smi_req(smi_req), .shutdown_req(shutdown_req), .reset_req(reset_req)
  );

  always #2 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  logic [TW-1:0] m_cnt = 0;
  logic [15:0] m_sts = 0, m_en = 0, m_ctl = 0;
  logic [7:0] m_cmd = 0, m_aps = 0, m_ard = 0;
  logic [31:0] m_rd = 0;
  logic m_smi = 0, m_off = 0, m_rst = 0;
  string rd_tag = "R12", ard_tag = "R9";

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h t=%0t", tag, got, exp, $time);
    end
  endtask

  function automatic logic [31:0] ref_read(logic [5:0] a);
    case (a)
      6'h00: return {16'h0, m_sts};
      6'h02: return {16'h0, m_en};
      6'h04: return {16'h0, m_ctl};
      6'h08: return {{(32-TW){1'b0}}, m_cnt};
      default: return 32'h0;
    endcase
  endfunction

  function automatic string read_tag(logic [5:0] a);
    case (a)
      6'h00: return "R4";
      6'h02: return "R5";
      6'h04: return "R6";
      6'h08: return "R2";
      default: return "R12";
    endcase
  endfunction

  // one cycle: drive at falling edge, predict, compare at next falling edge
  task automatic step(logic w, logic r, logic [5:0] a, logic [15:0] d,
                      logic aw, logic ar, logic as, logic [7:0] ad,
                      logic tk, logic pb, logic se);
    logic [TW-1:0] n_cnt;
    logic [15:0] n_sts, n_ctl, n_en;
    logic [7:0] n_cmd, n_aps, n_ard;
    logic [31:0] n_rd;
    logic ovf, go, n_off, n_rst;
    pm_wr = w; pm_rd = r; pm_addr = a; pm_wdata = d;
    apm_wr = aw; apm_rd = ar; apm_sel = as; apm_wdata = ad;
    tick_en = tk; pwrbtn_evt = pb; smi_cfg_en = se;
    ovf   = tk && (&m_cnt[TW-2:0]);
    n_cnt = tk ? m_cnt + 1'b1 : m_cnt;
    go    = w && a == 6'h04 && d[13];
    n_off = go && d[12:10] == 3'd0;
    n_rst = go && d[12:10] == 3'd1;
    n_sts = m_sts;
    if (w && a == 6'h00) n_sts = n_sts & ~d;
    if (n_rst) n_sts = n_sts | 16'h8100;
    if (ovf) n_sts[0] = 1'b1;
    if (pb && m_en[8]) n_sts[8] = 1'b1;
    n_en  = (w && a == 6'h02) ? d : m_en;
    n_ctl = (w && a == 6'h04) ? (d & 16'hDFFF) : m_ctl;
    if (aw && !as && ad == 8'hF1) n_ctl[0] = 1'b1;
    if (aw && !as && ad == 8'hF0) n_ctl[0] = 1'b0;
    n_cmd = (aw && !as) ? ad : m_cmd;
    n_aps = (aw && as) ? ad : m_aps;
    n_rd  = r ? ref_read(a) : m_rd;
    if (r) rd_tag = read_tag(a);
    n_ard = ar ? (as ? m_aps : m_cmd) : m_ard;
    if (ar) ard_tag = as ? "R11" : "R9";
    @(negedge clk);
    chk("R10 smi_req", {31'b0, smi_req}, {31'b0, aw && !as && se});
    chk("R7 shutdown_req", {31'b0, shutdown_req}, {31'b0, n_off});
    chk("R7 reset_req", {31'b0, reset_req}, {31'b0, n_rst});
    chk({rd_tag, " pm_rdata"}, pm_rdata, n_rd);
    chk({ard_tag, " apm_rdata"}, {24'b0, apm_rdata}, {24'b0, n_ard});
    chk("R5 sci", {31'b0, sci}, {31'b0, |(n_sts & n_en & 16'h0521)});
    m_cnt = n_cnt; m_sts = n_sts; m_en = n_en; m_ctl = n_ctl;
    m_cmd = n_cmd; m_aps = n_aps; m_rd = n_rd; m_ard = n_ard;
  endtask

  task automatic idle(logic tk);
    step(0, 0, 0, 0, 0, 0, 0, 0, tk, 0, 0);
  endtask

  task automatic rd_now(logic [5:0] a);
    step(0, 1, a, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin : watchdog
    #400000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 pm_rdata", pm_rdata, 32'h0);
    chk("R1 apm_rdata", {24'b0, apm_rdata}, 32'h0);
    chk("R1 outputs", {28'b0, sci, smi_req, shutdown_req, reset_req}, 32'h0);
    rst_n = 1'b1;
    rd_now(6'h00); chk("R1 status", pm_rdata, 32'h0);
    rd_now(6'h08); chk("R1 timer", pm_rdata, 32'h0);
    // R12: unmapped read gives zero
    step(1, 0, 6'h02, 16'hFFFF, 0, 0, 0, 0, 0, 0, 0);
    rd_now(6'h06); chk("R12 unmapped", pm_rdata, 32'h0);
    // R8: power button masked when enable bit 8 is 0
    step(1, 0, 6'h02, 16'h0000, 0, 0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0);
    rd_now(6'h00); chk("R8 masked button", pm_rdata, 32'h0);
    step(1, 0, 6'h02, 16'h0100, 0, 0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0);
    rd_now(6'h00); chk("R8 enabled button", pm_rdata, 32'h0100);
    chk("R8 sci", {31'b0, sci}, 32'h1);
    step(1, 0, 6'h00, 16'hFFFF, 0, 0, 0, 0, 0, 0, 0);
    // R3: timer overflow at top-bit rise
    repeat ((1 << (TW - 1)) - 1) idle(1);
    rd_now(6'h00); chk("R3 no flag before flip", pm_rdata, 32'h0);
    idle(1);
    rd_now(6'h00); chk("R3 flag on flip", pm_rdata, 32'h1);
    // R9 / R10: command bytes and SMI gating
    step(0, 0, 0, 0, 1, 0, 0, 8'hF1, 0, 0, 0);
    rd_now(6'h04); chk("R9 sci enable set", pm_rdata, 32'h1);
    step(1, 0, 6'h04, 16'h0000, 1, 0, 0, 8'hF1, 0, 0, 1);
    rd_now(6'h04); chk("R9 command wins", pm_rdata, 32'h1);
    step(0, 0, 0, 0, 1, 0, 0, 8'hF0, 0, 0, 0);
    rd_now(6'h04); chk("R9 sci enable clear", pm_rdata, 32'h0);
    // R6 / R7: suspend types 2, 0, 1
    step(1, 0, 6'h04, 16'h2800, 0, 0, 0, 0, 0, 0, 0);
    rd_now(6'h04); chk("R6 bit13 dropped", pm_rdata, 32'h0800);
    step(1, 0, 6'h04, 16'h2000, 0, 0, 0, 0, 0, 0, 0);
    step(1, 0, 6'h04, 16'h2400, 0, 0, 0, 0, 0, 0, 0);
    rd_now(6'h00); chk("R7 resume marks", pm_rdata & 32'h8100, 32'h8100);
    // R11
    step(0, 0, 0, 0, 1, 0, 1, 8'h5A, 0, 0, 0);
    step(0, 0, 0, 0, 0, 1, 1, 0, 0, 0, 0);
    chk("R11 status byte", {24'b0, apm_rdata}, 32'h5A);
    // random phase
    for (int i = 0; i < 6000; i++) begin
      logic [5:0] a;
      logic [15:0] d;
      logic [7:0] ad;
      case ($urandom_range(0, 4))
        0: a = 6'h00; 1: a = 6'h02; 2: a = 6'h04; 3: a = 6'h08;
        default: a = 6'($urandom);
      endcase
      d = 16'($urandom);
      if (a == 6'h04 && $urandom_range(0, 3) != 0) d[13] = 1'b0;
      ad = ($urandom_range(0, 2) == 0) ? (8'hF0 | 8'($urandom_range(0, 1))) : 8'($urandom);
      step($urandom_range(0, 3) == 0, $urandom_range(0, 1) == 0, a, d,
           $urandom_range(0, 5) == 0, $urandom_range(0, 1) == 0, 1'($urandom), ad,
           $urandom_range(0, 3) != 0, $urandom_range(0, 7) == 0, 1'($urandom));
    end
    $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  end
endmodule